// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer in which writer and reader share one clock. Words go into a small register array at a write address counter and come out at a read address counter. Each counter moves only when its own request is accepted. How many words are held is tracked by a separate up/down occupancy counter, and every status output comes from that counter and never from the difference of the two addresses.

Besides registered full and empty outputs, the block drives two vectors of level flags. Each bit of the fill vector reports that occupancy has reached a threshold chosen by a parameter. Each bit of the drain vector reports that occupancy has fallen to a threshold chosen by a second parameter. The two threshold lists are independent, and their lengths may differ. A parameter selects whether writes while full and reads while empty are blocked. Leaving the guard out shortens the request path, and the user must then keep the buffer from overflowing or underflowing.

Top module: `sync_level_fifo`

## Requirements
- R1: While `rst_n` is low and right after reset, `empty` is 1, `full` is 0, `rd_data` is 0, every `drain_lo` bit is 1 (an occupancy of zero is at or below any level), and each `fill_hi` bit is 1 only if its level is 0.
- R2: Words are read in the order they were written. `rd_data` takes the oldest stored word on the clock edge that accepts a read, so it is valid in the cycle after the read request.
- R3: Occupancy rises by one on each accepted write without an accepted read. `full` goes to 1 on the edge that takes occupancy to DEPTH (8 by default).
- R4: `empty` goes to 1 on the edge where an accepted read without a write takes occupancy from 1 to 0. It drops on the first accepted write without a read.
- R5: A write and a read that are both accepted in one cycle leave occupancy, `full`, `empty` and all level flags unchanged.
- R6: With the guard enabled (default), a write while `full` is ignored. The word is not stored and occupancy stays at DEPTH. A simultaneous read while full is still accepted.
- R7: With the guard enabled, a read while `empty` is ignored. `rd_data` keeps its value and occupancy stays 0. A simultaneous write while empty is still accepted.
- R8: `fill_hi[i]` is 1 exactly when occupancy is at or above entry i of FILL_LEVELS. Entry i sits in bits [32*i+31:32*i]; the defaults are 4 for bit 0 and 6 for bit 1.
- R9: `drain_lo[i]` is 1 exactly when occupancy is at or below entry i of DRAIN_LEVELS, laid out like FILL_LEVELS. The defaults are 0, 2 and 5 for bits 0, 1 and 2.
- R10: All flags are registers loaded from the next occupancy value, so they change on the same clock edge as the occupancy that they report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| fill_hi | output | N_FILL | At-or-above level flags |
| drain_lo | output | N_DRAIN | At-or-below level flags |

## Verification
The hardest cases to reach are requests that arrive together while the buffer sits at a boundary. One is a write and a read in the same cycle while full, where only the read may be accepted. The other is the same pair while empty, where only the write may be accepted. The stimulus table first fills the buffer to DEPTH and adds an extra write. It then issues a write and a read together and drains the buffer word by word past every drain threshold. Finally it repeats the paired request from the empty state. The expected occupancy and read word are listed for every step, so a dropped word, a word stored in error, or a flag that changes one edge late all show up.

// File: rtl/sync_level_fifo_pkg.sv
package sync_level_fifo_pkg;
   localparam int unsigned LEVEL_W = 32;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

   function automatic int unsigned count_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/slf_addr_ctr.sv
module slf_addr_ctr #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW = sync_level_fifo_pkg::addr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (step)
         addr <= (addr == LAST) ? '0 : addr + 1'b1;
   end

   // R2
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr <= LAST);
endmodule

// File: rtl/slf_store.sv
module slf_store #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW = sync_level_fifo_pkg::addr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         cells[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (re)
         rdata <= cells[raddr];
   end

   // R7
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata));
endmodule

// File: rtl/slf_occupancy.sv
module slf_occupancy #(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned N_FILL  = 2,
   parameter int unsigned N_DRAIN = 3,
   parameter logic [N_FILL*32-1:0]  FILL_LEVELS  = {32'd6, 32'd4},
   parameter logic [N_DRAIN*32-1:0] DRAIN_LEVELS = {32'd5, 32'd2, 32'd0},
   localparam int unsigned CW = sync_level_fifo_pkg::count_bits(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ok,
   input  logic               rd_ok,
   output logic               full,
   output logic               empty,
   output logic [N_FILL-1:0]  fill_hi,
   output logic [N_DRAIN-1:0] drain_lo
);
   import sync_level_fifo_pkg::*;

   logic [CW-1:0] occ, occ_nx;
   logic          grow, shrink;

   assign grow   = wr_ok & ~rd_ok;
   assign shrink = rd_ok & ~wr_ok;

   always_comb begin
      occ_nx = occ;
      if (grow)
         occ_nx = occ + 1'b1;
      else if (shrink)
         occ_nx = occ - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         occ <= '0;
      else
         occ <= occ_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full  <= 1'b0;
         empty <= 1'b1;
      end else if (grow) begin
         empty <= 1'b0;
         if (occ == CW'(DEPTH - 1))
            full <= 1'b1;
      end else if (shrink) begin
         full <= 1'b0;
         if (occ == CW'(1))
            empty <= 1'b1;
      end
   end

   for (genvar i = 0; i < N_FILL; i++) begin : g_fill
      localparam int unsigned LV = FILL_LEVELS[i*LEVEL_W +: LEVEL_W];
      if (LV > DEPTH) begin : g_bad
         $error("fill level beyond depth");
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fill_hi[i] <= (LV == 0);
         else
            fill_hi[i] <= (32'(occ_nx) >= LV);
      end
      // R8
      fill_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fill_hi[i] == (32'(occ) >= LV));
   end

   for (genvar i = 0; i < N_DRAIN; i++) begin : g_drain
      localparam int unsigned LV = DRAIN_LEVELS[i*LEVEL_W +: LEVEL_W];
      if (LV > DEPTH) begin : g_bad
         $error("drain level beyond depth");
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            drain_lo[i] <= 1'b1;
         else
            drain_lo[i] <= (32'(occ_nx) <= LV);
      end
      // R9
      drain_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         drain_lo[i] == (32'(occ) <= LV));
   end

   // R3
   full_at_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full == (occ == CW'(DEPTH)));
   // R4
   empty_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (occ == '0));
   // R5
   paired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && rd_ok) |=> ($stable(occ) && $stable(full) && $stable(empty)));
   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

// File: rtl/sync_level_fifo.sv
module sync_level_fifo #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned DEPTH   = 8,
   parameter bit          GUARD   = 1'b1,
   parameter int unsigned N_FILL  = 2,
   parameter int unsigned N_DRAIN = 3,
   parameter logic [N_FILL*32-1:0]  FILL_LEVELS  = {32'd6, 32'd4},
   parameter logic [N_DRAIN*32-1:0] DRAIN_LEVELS = {32'd5, 32'd2, 32'd0}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WIDTH-1:0]   wr_data,
   input  logic               rd_en,
   output logic [WIDTH-1:0]   rd_data,
   output logic               full,
   output logic               empty,
   output logic [N_FILL-1:0]  fill_hi,
   output logic [N_DRAIN-1:0] drain_lo
);
   localparam int unsigned AW = sync_level_fifo_pkg::addr_bits(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("WIDTH must be at least 1");
   end
   if (N_FILL < 1 || N_DRAIN < 1) begin : g_bad_lists
      $error("each level list needs at least one entry");
   end

   logic          wr_ok, rd_ok;
   logic [AW-1:0] waddr, raddr;

   if (GUARD) begin : g_guarded
      assign wr_ok = wr_en & ~full;
      assign rd_ok = rd_en & ~empty;

      // R6
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (full && wr_en && !rd_en) |=> (full && $stable(waddr)));
      // R7
      no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (empty && rd_en && !wr_en) |=> (empty && $stable(raddr) && $stable(rd_data)));
   end else begin : g_open
      assign wr_ok = wr_en;
      assign rd_ok = rd_en;
   end

   slf_addr_ctr #(.DEPTH(DEPTH)) u_wr_addr (
      .clk(clk), .rst_n(rst_n), .step(wr_ok), .addr(waddr)
   );

   slf_addr_ctr #(.DEPTH(DEPTH)) u_rd_addr (
      .clk(clk), .rst_n(rst_n), .step(rd_ok), .addr(raddr)
   );

   slf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_ok), .waddr(waddr), .wdata(wr_data),
      .re(rd_ok), .raddr(raddr), .rdata(rd_data)
   );

   slf_occupancy #(
      .DEPTH(DEPTH), .N_FILL(N_FILL), .N_DRAIN(N_DRAIN),
      .FILL_LEVELS(FILL_LEVELS), .DRAIN_LEVELS(DRAIN_LEVELS)
   ) u_occ (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok),
      .full(full), .empty(empty), .fill_hi(fill_hi), .drain_lo(drain_lo)
   );

   // R2
   addr_meet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty || full) |-> (waddr == raddr));
endmodule

// File: tb/sync_level_fifo_tb_top.sv
module sync_level_fifo_tb_top;
   localparam int unsigned W = 8;
   localparam int unsigned D = 8;
   localparam int unsigned NF = 2;
   localparam int unsigned ND = 3;
   localparam int unsigned FL [NF] = '{4, 6};
   localparam int unsigned DL [ND] = '{0, 2, 5};

   typedef struct packed {
      logic       wr;
      logic       rd;
      logic [7:0] din;
      logic [3:0] occ;
      logic       chk;
      logic [7:0] dout;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 8'hA1, 4'd1, 1'b0, 8'h00, 4'd3},  // R3
      '{1'b1, 1'b0, 8'hA2, 4'd2, 1'b0, 8'h00, 4'd3},  // R3
      '{1'b0, 1'b1, 8'h00, 4'd1, 1'b1, 8'hA1, 4'd2},  // R2
      '{1'b1, 1'b1, 8'hA3, 4'd1, 1'b1, 8'hA2, 4'd5},  // R5
      '{1'b1, 1'b0, 8'hA4, 4'd2, 1'b0, 8'h00, 4'd8},  // R8
      '{1'b1, 1'b0, 8'hA5, 4'd3, 1'b0, 8'h00, 4'd8},
      '{1'b1, 1'b0, 8'hA6, 4'd4, 1'b0, 8'h00, 4'd8},
      '{1'b1, 1'b0, 8'hA7, 4'd5, 1'b0, 8'h00, 4'd8},
      '{1'b1, 1'b0, 8'hA8, 4'd6, 1'b0, 8'h00, 4'd8},
      '{1'b1, 1'b0, 8'hA9, 4'd7, 1'b0, 8'h00, 4'd8},
      '{1'b1, 1'b0, 8'hAA, 4'd8, 1'b0, 8'h00, 4'd3},  // R3 full
      '{1'b1, 1'b0, 8'hAB, 4'd8, 1'b0, 8'h00, 4'd6},  // R6 ignored
      '{1'b1, 1'b1, 8'hAC, 4'd7, 1'b1, 8'hA3, 4'd6},  // R6 read only
      '{1'b0, 1'b1, 8'h00, 4'd6, 1'b1, 8'hA4, 4'd9},  // R9
      '{1'b0, 1'b1, 8'h00, 4'd5, 1'b1, 8'hA5, 4'd9},
      '{1'b0, 1'b1, 8'h00, 4'd4, 1'b1, 8'hA6, 4'd9},
      '{1'b0, 1'b1, 8'h00, 4'd3, 1'b1, 8'hA7, 4'd9},
      '{1'b0, 1'b1, 8'h00, 4'd2, 1'b1, 8'hA8, 4'd9},
      '{1'b0, 1'b1, 8'h00, 4'd1, 1'b1, 8'hA9, 4'd9},
      '{1'b0, 1'b1, 8'h00, 4'd0, 1'b1, 8'hAA, 4'd4},  // R4
      '{1'b0, 1'b1, 8'h00, 4'd0, 1'b1, 8'hAA, 4'd7},  // R7 ignored
      '{1'b1, 1'b1, 8'hAD, 4'd1, 1'b1, 8'hAA, 4'd7},  // R7 write only
      '{1'b0, 1'b1, 8'h00, 4'd0, 1'b1, 8'hAD, 4'd2}   // R2
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  rd_data;
   logic          full, empty;
   logic [NF-1:0] fill_hi;
   logic [ND-1:0] drain_lo;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sync_level_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
      .fill_hi(fill_hi), .drain_lo(drain_lo)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_levels(input string tag, input int occ);
      logic [NF-1:0] ef;
      logic [ND-1:0] ed;
      for (int j = 0; j < NF; j++) ef[j] = (occ >= FL[j]);
      for (int j = 0; j < ND; j++) ed[j] = (occ <= DL[j]);
      check({tag, " full"}, 32'(full), 32'(occ == D));
      check({tag, " empty"}, 32'(empty), 32'(occ == 0));
      check({tag, " fill_hi"}, 32'(fill_hi), 32'(ef));
      check({tag, " drain_lo"}, 32'(drain_lo), 32'(ed));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check_levels("R1 in reset", 0);
      check("R1 rd_data", 32'(rd_data), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_levels("R1 after reset", 0);

      // table walk: inputs set at a falling edge, results read at the next
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d step %0d", VECS[i].req, i);
         wr_en   = VECS[i].wr;
         rd_en   = VECS[i].rd;
         wr_data = VECS[i].din;
         @(negedge clk);
         check_levels(tag, int'(VECS[i].occ));
         if (VECS[i].chk)
            check({tag, " rd_data"}, 32'(rd_data), 32'(VECS[i].dout));
      end
      wr_en = 1'b0;
      rd_en = 1'b0;

      // R10: one write from empty moves empty and drain flag 0 on one edge
      wr_en = 1'b1; wr_data = 8'h5C;
      @(posedge clk);
      #1;
      check("R10 empty same edge", 32'(empty), 32'h0);
      check("R10 drain_lo[0] same edge", 32'(drain_lo[0]), 32'h0);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h5D;
      @(negedge clk);
      wr_en = 1'b0;
      check_levels("R10 two stored", 2);

      // R1 reset in mid run
      rst_n = 1'b0;
      #1;
      check_levels("R1 async reset", 0);
      check("R1 async rd_data", 32'(rd_data), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 read on fresh empty buffer ignored, then order holds after refill
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check_levels("R7 read after reset", 0);
      check("R7 rd_data held", 32'(rd_data), 32'h0);
      wr_en = 1'b1; wr_data = 8'h71;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R2 rd after reset", 32'(rd_data), 32'h71);
      check_levels("R4 drained again", 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule